// File: doc/BRIEF.md
# Boost Frequency Governor Datapath

This block turns watermark events from one activity-monitoring channel into a clock frequency request. Each update is triggered by a one-cycle `start` pulse. The pulse carries an up-event flag, a down-event flag, the latest averaged activity count and the current clock frequency.

The update does five things:
- It revises a boost term. An up event grows the boost geometrically and adds a fixed step; the boost saturates at the maximum frequency. A down event shrinks the boost geometrically; the boost drops to zero once it is smaller than half a step.
- It decides which of the two instantaneous-watermark enables stay set.
- It recomputes the two average watermarks around the new average count.
- It recomputes the two threshold watermarks from the channel's reference frequency.
- It converts the average count to an average frequency and outputs the target: the average frequency scaled by a sustain factor, plus the boost.

All divisions share one multi-cycle restoring divider. Every output register changes on the same clock edge, and `done` pulses on that edge. The channel type is chosen by `load_mode`. In a frequency-type channel (`load_mode`=0) the count tracks the measured clock itself. In a load-type channel (`load_mode`=1) the count tracks busy cycles of the monitor clock. Configuration inputs must be held stable while `busy` is high.

Top module: `boost_governor`

## Requirements
- R1: On an update whose up flag is 1, the new boost is step + (boost × up_coef) / 100, using integer division.
- R2: If that up result is greater than or equal to max_freq, the boost becomes max_freq and up_en is cleared to 0.
- R3: On an update whose down flag is 1 and whose up flag is 0, the new boost is (boost × down_coef) / 100.
- R4: If that down result is below step / 2 (integer), the boost becomes 0 and down_en is cleared to 0.
- R5: An update with either flag set first sets both up_en and down_en to 1, before the clearing of R2 or R4. When both flags are set, the update is treated as an up event only.
- R6: With bp = band_freq × period, avg_up_wm = avg + bp and avg_dn_wm = max(avg, bp) − bp.
- R7: up_wm = f × period × up_thr / 100 and down_wm = f × period × down_thr / 100. Here f is cur_freq when load_mode=0 and mon_freq when load_mode=1.
- R8: The average frequency is avg / period when load_mode=0, and (avg × cur_freq) / (mon_freq × period) when load_mode=1. With sustain = 10000 / up_thr, target_o = (avgfreq × sustain) / 100 + new boost. Every division truncates.
- R9: done rises exactly 6·(2W+2) cycles after the edge that accepts start, and lasts one cycle. All outputs change only on that edge.
- R10: While the block is busy, start is ignored. The event flags, avg_count and cur_freq are captured when start is accepted.
- R11: After reset, boost_o, target_o and all watermarks are 0, up_en and down_en are 1, and busy and done are 0.
- R12: An update with neither flag set leaves the boost, up_en and down_en unchanged, but still refreshes the watermarks and the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an update (accepted when not busy) |
| up_evt | input | 1 | Up-watermark event flag |
| down_evt | input | 1 | Down-watermark event flag |
| load_mode | input | 1 | 1 = load-type channel, 0 = frequency-type channel |
| avg_count | input | W | Latest averaged activity count |
| cur_freq | input | W | Current clock frequency (kHz) |
| mon_freq | input | W | Monitor clock frequency (kHz) |
| period | input | PW | Sampling period, must be nonzero |
| band_freq | input | W | Average-watermark band frequency |
| step | input | W | Boost step |
| max_freq | input | W | Boost ceiling |
| up_coef | input | CW | Up growth coefficient, percent |
| down_coef | input | CW | Down decay coefficient, percent |
| up_thr | input | CW | Up threshold, percent, nonzero |
| down_thr | input | CW | Down threshold, percent |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse when outputs update |
| boost_o | output | W | Current boost term |
| target_o | output | W | Target frequency |
| up_wm | output | W | Up threshold watermark |
| down_wm | output | W | Down threshold watermark |
| avg_up_wm | output | W | Average up watermark |
| avg_dn_wm | output | W | Average down watermark |
| up_en | output | 1 | Up-watermark enable |
| down_en | output | 1 | Down-watermark enable |

## Verification
Every result of an update is due at once, 6·(2W+2) = 396 cycles after the edge that takes `start` at the default width. Nothing changes before that edge. The bench drives inputs at the falling edge and counts falling edges from the start pulse until `done` is seen. It requires that count to equal the latency exactly. It then compares all outputs at that same falling edge and checks that `done` is low one cycle later. A second start pulse with altered flags and counts, sent in the middle of an update, shows that the captured values are the ones used.

// File: rtl/boost_governor.sv
module boost_governor #(
  parameter int W  = 32,
  parameter int PW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          up_evt,
  input  logic          down_evt,
  input  logic          load_mode,
  input  logic [W-1:0]  avg_count,
  input  logic [W-1:0]  cur_freq,
  input  logic [W-1:0]  mon_freq,
  input  logic [PW-1:0] period,
  input  logic [W-1:0]  band_freq,
  input  logic [W-1:0]  step,
  input  logic [W-1:0]  max_freq,
  input  logic [CW-1:0] up_coef,
  input  logic [CW-1:0] down_coef,
  input  logic [CW-1:0] up_thr,
  input  logic [CW-1:0] down_thr,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  boost_o,
  output logic [W-1:0]  target_o,
  output logic [W-1:0]  up_wm,
  output logic [W-1:0]  down_wm,
  output logic [W-1:0]  avg_up_wm,
  output logic [W-1:0]  avg_dn_wm,
  output logic          up_en,
  output logic          down_en
);
  localparam int DW   = 2 * W;
  localparam int CNTW = $clog2(DW + 1);
  localparam int LAST = 5;

  logic            run, ld, up_l, dn_l;
  logic [2:0]      ph;
  logic [W-1:0]    avg_l, cur_l, bst, wu, wd, sus, afq;
  logic            ue, de;
  logic [DW-1:0]   quo, den, rem, nnum, nden;
  logic [CNTW-1:0] dcnt;

  wire [DW:0]   rem_sh = {rem, quo[DW-1]};
  wire          fits   = rem_sh >= {1'b0, den};
  wire [W-1:0]  q      = quo[W-1:0];
  wire [W-1:0]  fbase  = load_mode ? mon_freq : cur_l;
  wire [W-1:0]  band_p = band_freq * W'(period);
  wire [W-1:0]  avg_hi = (avg_l > band_p) ? avg_l : band_p;
  wire [W:0]    up_sum = {1'b0, step} + {1'b0, q};

  assign busy = run;

  always_comb begin
    nden = DW'(100);
    case (ph)
      3'd0: nnum = DW'(boost_o) * DW'(up_l ? up_coef : down_coef);
      3'd1: nnum = DW'(fbase) * DW'(period) * DW'(up_thr);
      3'd2: nnum = DW'(fbase) * DW'(period) * DW'(down_thr);
      3'd3: begin nnum = DW'(10000); nden = DW'(up_thr); end
      3'd4: begin
        if (load_mode) begin
          nnum = DW'(avg_l) * DW'(cur_l);
          nden = DW'(mon_freq) * DW'(period);
        end else begin
          nnum = DW'(avg_l);
          nden = DW'(period);
        end
      end
      default: nnum = DW'(afq) * DW'(sus);
    endcase
  end

  logic [W-1:0] nb;
  logic         nue, nde;
  always_comb begin
    nb = boost_o; nue = up_en; nde = down_en;
    if (up_l) begin
      nue = 1'b1; nde = 1'b1;
      if (up_sum >= {1'b0, max_freq}) begin nb = max_freq; nue = 1'b0; end
      else nb = up_sum[W-1:0];
    end else if (dn_l) begin
      nue = 1'b1; nde = 1'b1;
      if (q < (step >> 1)) begin nb = '0; nde = 1'b0; end
      else nb = q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; ld <= 1'b0; done <= 1'b0; ph <= '0;
      up_l <= 1'b0; dn_l <= 1'b0; avg_l <= '0; cur_l <= '0;
      bst <= '0; wu <= '0; wd <= '0; sus <= '0; afq <= '0; ue <= 1'b1; de <= 1'b1;
      quo <= '0; den <= '0; rem <= '0; dcnt <= '0;
      boost_o <= '0; target_o <= '0; up_wm <= '0; down_wm <= '0;
      avg_up_wm <= '0; avg_dn_wm <= '0; up_en <= 1'b1; down_en <= 1'b1;
    end else if (!run) begin
      done <= 1'b0;
      if (start) begin
        run <= 1'b1; ld <= 1'b1; ph <= '0;
        up_l <= up_evt; dn_l <= down_evt; avg_l <= avg_count; cur_l <= cur_freq;
      end
    end else if (ld) begin
      quo <= nnum; den <= nden; rem <= '0; dcnt <= CNTW'(DW); ld <= 1'b0;
    end else if (dcnt != '0) begin
      rem  <= fits ? DW'(rem_sh - {1'b0, den}) : rem_sh[DW-1:0];
      quo  <= {quo[DW-2:0], fits};
      dcnt <= dcnt - 1'b1;
    end else begin
      case (ph)
        3'd0: begin bst <= nb; ue <= nue; de <= nde; end
        3'd1: wu  <= q;
        3'd2: wd  <= q;
        3'd3: sus <= q;
        3'd4: afq <= q;
        default: begin
          target_o  <= q + bst;
          boost_o   <= bst;
          up_en     <= ue;
          down_en   <= de;
          up_wm     <= wu;
          down_wm   <= wd;
          avg_up_wm <= avg_l + band_p;
          avg_dn_wm <= avg_hi - band_p;
        end
      endcase
      if (ph == 3'(LAST)) begin run <= 1'b0; done <= 1'b1; end
      else begin ph <= ph + 1'b1; ld <= 1'b1; end
    end
  end

  p_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && up_l && !up_en |-> boost_o == max_freq);
  p_collapse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && dn_l && !up_l && !down_en |-> boost_o == '0);
  p_rearm_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && up_l |-> down_en);
  p_rearm_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && dn_l && !up_l |-> up_en);
  p_avg_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> avg_dn_wm <= avg_up_wm);
  p_atomic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(target_o) && $stable(boost_o) && $stable(up_wm));
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/test_boost_governor.sv
module test_boost_governor;
  localparam int W = 32, PW = 8, CW = 8;
  localparam int CLK_NS = 10;
  localparam int LAT = 6 * (2 * W + 2);
  localparam longint M = 64'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, up_evt = 1'b0, down_evt = 1'b0, load_mode = 1'b0;
  logic [W-1:0] avg_count = '0, cur_freq = '0, mon_freq = '0, band_freq = '0, step = '0, max_freq = '0;
  logic [PW-1:0] period = '0;
  logic [CW-1:0] up_coef = '0, down_coef = '0, up_thr = '0, down_thr = '0;
  logic busy, done, up_en, down_en;
  logic [W-1:0] boost_o, target_o, up_wm, down_wm, avg_up_wm, avg_dn_wm;

  boost_governor #(.W(W), .PW(PW), .CW(CW)) i_boost_governor (.*);

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0;
  longint m_boost = 0;
  bit m_ue = 1, m_de = 1;

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic longint wm_exp(input longint thr);
    longint f = load_mode ? longint'(mon_freq) : longint'(cur_freq);
    return ((f * period * thr) / 100) & M;
  endfunction

  function automatic longint tgt_exp(input longint bst);
    longint sus = 10000 / longint'(up_thr);
    longint afq = load_mode ? (longint'(avg_count) * cur_freq) / (longint'(mon_freq) * period)
                            : longint'(avg_count) / period;
    afq = afq & M;
    return ((((afq * sus) / 100) & M) + bst) & M;
  endfunction

  task automatic model(input bit u, input bit d);
    longint v;
    if (u) begin
      v = longint'(step) + (m_boost * up_coef) / 100;
      m_ue = 1; m_de = 1;
      if (v >= max_freq) begin v = max_freq; m_ue = 0; end
      m_boost = v;
    end else if (d) begin
      v = (m_boost * down_coef) / 100;
      m_ue = 1; m_de = 1;
      if (v < longint'(step) / 2) begin v = 0; m_de = 0; end
      m_boost = v;
    end
  endtask

  task automatic update(input bit u, input bit d, input bit poke);
    int cyc = 0;
    longint bp, eau, ead;
    string btag;
    @(negedge clk);
    up_evt = u; down_evt = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < LAT + 20) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 5) begin
        start = 1'b1; up_evt = ~u; down_evt = ~d; avg_count = avg_count + 1;
      end
      if (poke && cyc == 6) begin
        start = 1'b0; up_evt = u; down_evt = d; avg_count = avg_count - 1;
      end
    end
    chk("R9", "latency", cyc, LAT);
    model(u, d);
    btag = u ? "R1" : (d ? "R3" : "R12");
    chk(btag, "boost", boost_o, m_boost);
    chk(u ? "R2" : "R5", "up_en", up_en, m_ue);
    chk(d && !u ? "R4" : "R5", "down_en", down_en, m_de);
    chk("R7", "up_wm", up_wm, wm_exp(up_thr));
    chk("R7", "down_wm", down_wm, wm_exp(down_thr));
    bp  = (longint'(band_freq) * period) & M;
    eau = (longint'(avg_count) + bp) & M;
    ead = ((avg_count > bp) ? longint'(avg_count) : bp) - bp;
    chk("R6", "avg_up_wm", avg_up_wm, eau);
    chk("R6", "avg_dn_wm", avg_dn_wm, ead);
    chk("R8", "target", target_o, tgt_exp(m_boost));
    if (poke) chk("R10", "busy start ignored", busy, 0);
    @(negedge clk);
    chk("R9", "done pulse", done, 0);
  endtask

  task automatic defaults();
    step = 16000; up_coef = 200; down_coef = 50; up_thr = 60; down_thr = 40;
    max_freq = 800000; period = 12; cur_freq = 400000; mon_freq = 50000;
    avg_count = 4800000; band_freq = 4800; load_mode = 1'b0;
  endtask

  task automatic rand_cfg();
    load_mode = 1'($urandom_range(0, 1));
    step      = $urandom_range(1000, 20000);
    max_freq  = $urandom_range(200000, 1 << 22);
    up_coef   = CW'($urandom_range(100, 255));
    down_coef = CW'($urandom_range(10, 90));
    up_thr    = CW'($urandom_range(50, 100));
    down_thr  = CW'($urandom_range(10, 49));
    period    = PW'($urandom_range(1, 255));
    cur_freq  = $urandom_range(1000, 1 << 20);
    mon_freq  = $urandom_range(1 << 16, 1 << 20);
    avg_count = $urandom_range(0, 1 << 24);
    band_freq = $urandom_range(0, 1 << 16);
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    defaults();
    repeat (3) @(negedge clk);
    chk("R11", "boost", boost_o, 0);
    chk("R11", "target", target_o, 0);
    chk("R11", "up_wm", up_wm, 0);
    chk("R11", "avg_up_wm", avg_up_wm, 0);
    chk("R11", "up_en", up_en, 1);
    chk("R11", "down_en", down_en, 1);
    chk("R11", "busy", busy, 0);
    chk("R11", "done", done, 0);
    rst_n = 1'b1;
    update(1, 0, 0);
    chk("R1", "first step", boost_o, 16000);
    update(1, 0, 0);
    chk("R1", "geometric", boost_o, 48000);
    update(0, 0, 0);
    update(1, 1, 0);
    chk("R5", "up priority", boost_o, 112000);
    update(0, 1, 0);
    chk("R3", "halve", boost_o, 56000);
    update(0, 1, 0);
    update(0, 1, 0);
    update(0, 1, 0);
    chk("R4", "collapse", boost_o, 0);
    chk("R4", "down_en cleared", down_en, 0);
    update(0, 0, 0);
    chk("R12", "down_en kept", down_en, 0);
    max_freq = 100000;
    update(1, 0, 0);
    update(1, 0, 0);
    update(1, 0, 0);
    chk("R2", "clamp", boost_o, 100000);
    chk("R2", "up_en cleared", up_en, 0);
    update(0, 1, 0);
    chk("R5", "up_en rearmed", up_en, 1);
    load_mode = 1'b1;
    update(1, 0, 1);
    update(0, 1, 1);
    for (int i = 0; i < 45; i++) begin
      bit u, d;
      rand_cfg();
      u = 1'($urandom_range(0, 1));
      d = 1'($urandom_range(0, 1));
      update(u, d, (i % 7) == 3);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule